// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single read or write requests from on-chip logic into bus cycles on an external bus whose pins carry the address first and then the data. Every cycle runs through four phases. An address phase is marked by a one-clock start strobe. A data phase repeats as wait states until the transfer is acknowledged. A capture phase follows, then a hold phase that keeps the pins steady. After the hold phase a one-clock done pulse reports completion.

A cycle can end in two ways. In the first, an internal counter acknowledges on its own after a chosen number of wait states; a low on the external acknowledge line also ends the cycle, whichever comes first. In the second, only the active-low external acknowledge line ends it. The data occupies the upper `DATA_W` pins of the `BUS_W`-wide bus. The lower pins keep carrying the low address bits during the data phases. A ready/valid pair holds off new requests while a cycle is running.

Top module: `mux_bus_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `bus_cs_n`=1, `bus_start`=0, `bus_ad_oe`=0, `rsp_done`=0, `bus_rnw`=1.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle (address phase) `bus_start`=1, `bus_ad_o` is the full address, `bus_ad_oe` is all ones, `bus_rnw` equals the request's `req_rnw` (1 = read), `bus_cs_n`=1 and `req_ready`=0.
- R3: In every data-phase clock `bus_start`=0 and `bus_cs_n`=0. Bits [BUS_W-1:BUS_W-DATA_W] carry the write data with enable 1 for a write, and have enable 0 for a read. Bits [BUS_W-DATA_W-1:0] carry the low address bits with enable 1.
- R4: With `cfg_auto_ack`=1 the data phase lasts `cfg_wait`+1 clocks (0 to 63 wait states), or fewer if the external acknowledge comes earlier. `cfg_auto_ack` and `cfg_wait` are sampled only when the request is taken.
- R5: With `cfg_auto_ack`=0 the data phase repeats until `bus_ack_n` is sampled low during a data-phase clock. A low `bus_ack_n` in any other phase has no effect.
- R6: For a read, `rsp_rdata` is loaded from `bus_ad_i[BUS_W-1:BUS_W-DATA_W]` at the edge that ends the data phase. It then holds its value through writes until the next read is captured.
- R7: In the capture phase `bus_cs_n`=1 if the internal counter ended the cycle and 0 if the external acknowledge ended it. When both occur together, the internal counter takes priority. `bus_cs_n`=1 in the hold phase.
- R8: In the capture and hold phases `bus_ad_o`, `bus_ad_oe` and `bus_rnw` keep their data-phase values. Back in idle `bus_ad_oe`=0.
- R9: `rsp_done` is 1 for exactly the one clock after the hold phase, and `req_ready`=1 in that same clock.
- R10: A request held valid during a running cycle is taken at the edge that ends the done clock. Its address phase follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | BUS_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_rnw | input | 1 | 1 = read, 0 = write |
| cfg_auto_ack | input | 1 | 1 = internal auto-acknowledge enabled |
| cfg_wait | input | WAIT_W | Wait states before auto-acknowledge |
| rsp_rdata | output | DATA_W | Last captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_ad_o | output | BUS_W | Multiplexed address/data out |
| bus_ad_oe | output | BUS_W | Per-pin output enable |
| bus_ad_i | input | BUS_W | Multiplexed bus in |
| bus_start | output | 1 | Transfer start / address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rnw | output | 1 | Read/write line, 1 = read |
| bus_ack_n | input | 1 | External transfer acknowledge, active low |

## Verification
The assertions check the following rules on every clock:
- the start strobe is a single clock and is followed by an asserted chip select;
- a taken request always leads to a strobe;
- the data phase stays put while the external acknowledge is high in external mode, and leaves on time when the internal counter expires;
- the wait counter never passes its limit;
- read data changes only at a capture;
- bus pins are stable in the hold phase;
- chip select is high there;
- done lasts one clock.

Only the bench scenarios can show the following: exact data-phase lengths, including 63 wait states; that configuration changed mid-cycle is ignored; that acknowledge lows outside the data phase are ignored; the chip-select difference between the two termination kinds; the pin values in each phase; and that a waiting request is taken right after done.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_DATA = 3'd2,
      ST_CAPT = 3'd3,
      ST_HOLD = 3'd4
   } mbm_phase_e;
endpackage

// File: rtl/mbm_wait_ctr.sv
module mbm_wait_ctr #(
   parameter int WAIT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [WAIT_W-1:0] limit,
   output logic              hit
);
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step && !hit)
         cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (cnt_q == limit);

   // R4
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || step) |=> (cnt_q <= limit));
endmodule

// File: rtl/mbm_fsm.sv
module mbm_fsm
   import mbm_pkg::*;
#(
   parameter int WAIT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic              auto_in,
   input  logic [WAIT_W-1:0] wait_in,
   input  logic              ack_n,
   output mbm_phase_e        phase,
   output logic              ext_term,
   output logic              cap_en,
   output logic              done,
   output logic              ready
);
   mbm_phase_e        phase_q, phase_d;
   logic              auto_q;
   logic [WAIT_W-1:0] wait_q;
   logic              cnt_hit, ack_int, data_ack;

   mbm_wait_ctr #(.WAIT_W(WAIT_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_q == ST_ADDR),
      .step  (phase_q == ST_DATA),
      .limit (wait_q),
      .hit   (cnt_hit)
   );

   assign ack_int  = auto_q && cnt_hit;
   assign data_ack = (phase_q == ST_DATA) && (ack_int || !ack_n);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         ST_IDLE: if (req_fire) phase_d = ST_ADDR;
         ST_ADDR: phase_d = ST_DATA;
         ST_DATA: if (data_ack) phase_d = ST_CAPT;
         ST_CAPT: phase_d = ST_HOLD;
         ST_HOLD: phase_d = ST_IDLE;
         default: phase_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= ST_IDLE;
         auto_q   <= 1'b0;
         wait_q   <= '0;
         ext_term <= 1'b0;
         done     <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= (phase_q == ST_HOLD);
         if (req_fire) begin
            auto_q <= auto_in;
            wait_q <= wait_in;
         end
         if (data_ack)
            ext_term <= !ack_int;
      end
   end

   assign phase  = phase_q;
   assign cap_en = data_ack;
   assign ready  = (phase_q == ST_IDLE);

   // R5
   ext_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_DATA && !auto_q && ack_n) |=> (phase_q == ST_DATA));
   // R4
   auto_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_DATA && auto_q && cnt_hit) |=> (phase_q == ST_CAPT));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mbm_ad_path.sv
module mbm_ad_path
   import mbm_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [BUS_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_rnw,
   input  mbm_phase_e        phase,
   input  logic              ext_term,
   input  logic              cap_en,
   input  logic [BUS_W-1:0]  bus_ad_i,
   output logic [BUS_W-1:0]  bus_ad_o,
   output logic [BUS_W-1:0]  bus_ad_oe,
   output logic              bus_start,
   output logic              bus_cs_n,
   output logic              bus_rnw,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int LO_W = BUS_W - DATA_W;

   logic [BUS_W-1:0]  addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rnw_q;
   logic [BUS_W-1:0]  dat_word, dat_oe;
   logic              in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wdata_q   <= '0;
         rnw_q     <= 1'b1;
         rsp_rdata <= '0;
      end else begin
         if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rnw_q   <= req_rnw;
         end
         if (cap_en && rnw_q)
            rsp_rdata <= bus_ad_i[BUS_W-1 -: DATA_W];
      end
   end

   generate
      if (LO_W > 0) begin : g_split
         assign dat_word = {(rnw_q ? {DATA_W{1'b0}} : wdata_q), addr_q[LO_W-1:0]};
         assign dat_oe   = {{DATA_W{!rnw_q}}, {LO_W{1'b1}}};
         logic unused_lo;
         assign unused_lo = &{1'b0, bus_ad_i[LO_W-1:0]};
      end else begin : g_full
         assign dat_word = rnw_q ? {BUS_W{1'b0}} : wdata_q;
         assign dat_oe   = {BUS_W{!rnw_q}};
      end
   endgenerate

   assign in_data = (phase == ST_DATA) || (phase == ST_CAPT) || (phase == ST_HOLD);

   always_comb begin
      bus_ad_o  = '0;
      bus_ad_oe = '0;
      if (phase == ST_ADDR) begin
         bus_ad_o  = addr_q;
         bus_ad_oe = '1;
      end else if (in_data) begin
         bus_ad_o  = dat_word;
         bus_ad_oe = dat_oe;
      end
   end

   assign bus_start = (phase == ST_ADDR);
   assign bus_cs_n  = !((phase == ST_DATA) || (phase == ST_CAPT && ext_term));
   assign bus_rnw   = (phase == ST_IDLE) ? 1'b1 : rnw_q;

   // R6
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(rsp_rdata));
   // R8
   hold_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_CAPT) |=> ($stable(bus_ad_o) && $stable(bus_ad_oe) && $stable(bus_rnw)));
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
   import mbm_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int DATA_W = 16,
   parameter int WAIT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_rnw,
   input  logic              cfg_auto_ack,
   input  logic [WAIT_W-1:0] cfg_wait,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic [BUS_W-1:0]  bus_ad_o,
   output logic [BUS_W-1:0]  bus_ad_oe,
   input  logic [BUS_W-1:0]  bus_ad_i,
   output logic              bus_start,
   output logic              bus_cs_n,
   output logic              bus_rnw,
   input  logic              bus_ack_n
);
   generate
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_data_w
         $error("mux_bus_master: DATA_W must lie in 1..BUS_W");
      end
      if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait_w
         $error("mux_bus_master: WAIT_W must lie in 1..16");
      end
   endgenerate

   mbm_phase_e phase;
   logic       ext_term, cap_en, req_fire;

   assign req_fire = req_valid && req_ready;

   mbm_fsm #(.WAIT_W(WAIT_W)) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .auto_in  (cfg_auto_ack),
      .wait_in  (cfg_wait),
      .ack_n    (bus_ack_n),
      .phase    (phase),
      .ext_term (ext_term),
      .cap_en   (cap_en),
      .done     (rsp_done),
      .ready    (req_ready)
   );

   mbm_ad_path #(.BUS_W(BUS_W), .DATA_W(DATA_W)) path_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_rnw   (req_rnw),
      .phase     (phase),
      .ext_term  (ext_term),
      .cap_en    (cap_en),
      .bus_ad_i  (bus_ad_i),
      .bus_ad_o  (bus_ad_o),
      .bus_ad_oe (bus_ad_oe),
      .bus_start (bus_start),
      .bus_cs_n  (bus_cs_n),
      .bus_rnw   (bus_rnw),
      .rsp_rdata (rsp_rdata)
   );

   // R2
   take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> (bus_start && bus_cs_n));
   // R3
   strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (!bus_start && !bus_cs_n));
   // R7
   hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_HOLD) |-> bus_cs_n);
endmodule

// File: tb/mux_bus_master_tb_top.sv
module mux_bus_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_rnw = 1'b1;
   logic        cfg_auto_ack = 1'b1;
   logic [5:0]  cfg_wait = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_done;
   logic [31:0] bus_ad_o, bus_ad_oe;
   logic [31:0] bus_ad_i = '0;
   logic        bus_start, bus_cs_n, bus_rnw;
   logic        bus_ack_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] exp_rdata = '0;

   always #5 clk = ~clk;

   mux_bus_master dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_rnw(req_rnw),
      .cfg_auto_ack(cfg_auto_ack), .cfg_wait(cfg_wait), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
      .bus_ad_i(bus_ad_i), .bus_start(bus_start), .bus_cs_n(bus_cs_n),
      .bus_rnw(bus_rnw), .bus_ack_n(bus_ack_n)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   // one full transfer; ack_idx = data-phase clock (1-based) with external ack low, 0 = none
   task automatic do_xfer(input logic [31:0] a, input logic [15:0] wd, input bit rnw,
                          input bit auto_m, input logic [5:0] w, input int ack_idx,
                          input logic [15:0] rd);
      int n1;
      bit ext;
      logic [31:0] dw, doe;
      if (auto_m && (ack_idx == 0 || ack_idx >= int'(w) + 1)) begin
         n1 = int'(w) + 1; ext = 1'b0;
      end else begin
         n1 = ack_idx; ext = 1'b1;
      end
      dw  = {(rnw ? 16'h0000 : wd), a[15:0]};
      doe = {(rnw ? 16'h0000 : 16'hffff), 16'hffff};
      @(negedge clk);
      chk(req_ready === 1'b1, "R9 ready before request", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_addr = a; req_wdata = wd; req_rnw = rnw;
      cfg_auto_ack = auto_m; cfg_wait = w;
      @(negedge clk);
      // address phase; change config and inputs to check they are ignored
      req_valid = 1'b0; cfg_auto_ack = !auto_m; cfg_wait = ~w;
      req_addr = ~a; req_wdata = ~wd; req_rnw = !rnw;
      if (ack_idx != 0) bus_ack_n = 1'b0;
      chk(bus_start === 1'b1 && bus_cs_n === 1'b1 && req_ready === 1'b0, "R2 strobe/cs/ready",
          {61'd0, bus_start, bus_cs_n, req_ready}, 64'h6);
      chk(bus_ad_o === a && bus_ad_oe === 32'hffff_ffff && bus_rnw === rnw, "R2 address pins",
          {bus_ad_o, bus_ad_oe}, {a, 32'hffff_ffff});
      for (int k = 1; k <= n1; k++) begin
         @(negedge clk);
         bus_ack_n = (k == ack_idx) ? 1'b0 : 1'b1;
         bus_ad_i  = (k == n1) ? {rd, 16'h1c3e} : (32'h7700_0000 ^ k);
         chk(bus_start === 1'b0 && bus_cs_n === 1'b0, "R3 data phase strobe/cs",
             {62'd0, bus_start, bus_cs_n}, 64'd0);
         chk(bus_ad_o === dw && bus_ad_oe === doe && bus_rnw === rnw, "R3 data phase pins",
             {bus_ad_o, bus_ad_oe}, {dw, doe});
      end
      @(negedge clk);
      // capture phase
      bus_ad_i = 32'h0bad_0bad;
      if (ack_idx != 0) bus_ack_n = 1'b0;
      if (rnw) exp_rdata = rd;
      chk(bus_start === 1'b0 && bus_cs_n === !ext, "R4 R5 R7 data phase length / capture cs",
          {62'd0, bus_start, bus_cs_n}, {62'd0, 1'b0, !ext});
      chk(rsp_rdata === exp_rdata, "R6 read data", {48'd0, rsp_rdata}, {48'd0, exp_rdata});
      chk(bus_ad_o === dw && bus_ad_oe === doe && bus_rnw === rnw, "R8 capture pins held",
          {bus_ad_o, bus_ad_oe}, {dw, doe});
      @(negedge clk);
      // hold phase
      chk(bus_cs_n === 1'b1 && rsp_done === 1'b0, "R7 hold cs high",
          {62'd0, bus_cs_n, rsp_done}, 64'h2);
      chk(bus_ad_o === dw && bus_ad_oe === doe && bus_rnw === rnw, "R8 hold pins held",
          {bus_ad_o, bus_ad_oe}, {dw, doe});
      @(negedge clk);
      bus_ack_n = 1'b1;
      chk(rsp_done === 1'b1 && req_ready === 1'b1 && bus_ad_oe === 32'h0, "R9 done/ready, R8 released",
          {30'd0, rsp_done, req_ready, bus_ad_oe}, {30'd0, 2'b11, 32'h0});
      @(negedge clk);
      chk(rsp_done === 1'b0, "R9 done one clock", {63'd0, rsp_done}, 64'd0);
      chk(rsp_rdata === exp_rdata, "R6 read data held", {48'd0, rsp_rdata}, {48'd0, exp_rdata});
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && bus_cs_n === 1'b1 && bus_start === 1'b0 && rsp_done === 1'b0
          && bus_ad_oe === 32'h0 && bus_rnw === 1'b1, "R1 reset state",
          {58'd0, req_ready, bus_cs_n, bus_start, rsp_done, |bus_ad_oe, bus_rnw}, 64'h31);
   endtask

   task automatic t_back_to_back();
      int guard;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h1111_2222; req_wdata = 16'h3333; req_rnw = 1'b0;
      cfg_auto_ack = 1'b1; cfg_wait = 6'd1;
      @(negedge clk);
      req_addr = 32'h4444_5555; req_wdata = 16'h6666;
      guard = 0;
      while (rsp_done !== 1'b1 && guard < 20) begin
         chk(req_ready === 1'b0, "R10 held off while busy", {63'd0, req_ready}, 64'd0);
         @(negedge clk);
         guard++;
      end
      chk(rsp_done === 1'b1 && req_ready === 1'b1, "R10 done with ready",
          {62'd0, rsp_done, req_ready}, 64'h3);
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_start === 1'b1 && bus_ad_o === 32'h4444_5555, "R10 second request started",
          {31'd0, bus_start, bus_ad_o}, {31'd0, 1'b1, 32'h4444_5555});
      guard = 0;
      while (rsp_done !== 1'b1 && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      chk(rsp_done === 1'b1, "R10 second request finished", {63'd0, rsp_done}, 64'd1);
      chk(rsp_rdata === exp_rdata, "R6 writes leave read data", {48'd0, rsp_rdata}, {48'd0, exp_rdata});
   endtask

   initial begin
      t_reset();
      // R4 zero-wait write, auto mode
      do_xfer(32'ha5a5_1234, 16'hbeef, 1'b0, 1'b1, 6'd0, 0, 16'h0000);
      // R4 R6 read with three wait states
      do_xfer(32'h0f0f_8765, 16'h0000, 1'b1, 1'b1, 6'd3, 0, 16'h5a5a);
      // R6 write keeps previous read data
      do_xfer(32'h2468_ace0, 16'hc0de, 1'b0, 1'b1, 6'd2, 0, 16'h0000);
      // R5 R7 external-only mode, ack in third data clock, noise on ack elsewhere
      do_xfer(32'h1357_9bdf, 16'h0000, 1'b1, 1'b0, 6'd0, 3, 16'h1357);
      // R4 R7 auto mode ended early by external ack
      do_xfer(32'hfeed_0042, 16'h0000, 1'b1, 1'b1, 6'd5, 2, 16'h9abc);
      // R7 both sources in the same clock: internal wins
      do_xfer(32'h0000_00ff, 16'h7777, 1'b0, 1'b1, 6'd1, 2, 16'h0000);
      // R4 maximum wait count
      do_xfer(32'hcafe_f00d, 16'h0000, 1'b1, 1'b1, 6'd63, 0, 16'h4321);
      // R10 request waiting during a cycle
      t_back_to_back();
      finish_run();
   end
endmodule